// File: doc/BRIEF.md
# Scaled-Image VGA Display Controller

This block produces the timing and colour for a monitor running an 800x600 frame at 60 Hz, fed from a 50 MHz system clock. A divider gives a clock enable on one cycle in five. Every enabled cycle steps a horizontal position counter, and every completed line steps a vertical counter. Both sync pulses and the blanking window are decoded from those two counts. Each scan position advances once per enable, so a line has 200 positions, a quarter of the nominal 800.

Inside the visible window the block reads a 100x75 image from a built-in ROM. Each word is 6 bits. Every image pixel is shown twice across and on eight lines down, which fills 200 positions by 600 lines. The ROM contents come from a function that is evaluated when the design is elaborated, so no data file is needed. The read is registered. Sync and blanking pass through a matching register, so colour and timing stay together on the outputs. Each channel has four levels, standing for 0x00, 0x55, 0xAA and 0xFF on the monitor side.

Top module: `vga_lowres_display`

## Requirements
- R1: While `rst_n` is low at a rising edge, the divider, both counters and the output stage are cleared, so `hsync`, `vsync`, `red`, `green` and `blue` read 0. After release, the outputs for position (h=0, v=0) appear after the 5th rising edge with `rst_n` high.
- R2: The scan position on the outputs advances exactly once every 5 clock cycles.
- R3: A line lasts 264 positions, which is 1320 clocks. `hsync` is active high for positions 210 to 241 inclusive, which is 32 positions or 160 clocks.
- R4: A frame lasts 628 lines. `vsync` is active high for lines 601 to 604 inclusive. The vertical count advances only at the last position of a line.
- R5: `red`, `green` and `blue` are 0 at every position with h >= 200 or v >= 600.
- R6: At a visible position (h, v), the displayed word is the ROM word at address (v/8)*100 + h/2, using integer division.
- R7: ROM word at address a is a[5:0] XOR a[11:6]. Bits 5:4 drive `red`, bits 3:2 drive `green` and bits 1:0 drive `blue`.
- R8: Sync and colour on the outputs always describe the same scan position, and they change only one clock after a divider enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| red | output | 2 | Red level, 0 to 3 |
| green | output | 2 | Green level, 0 to 3 |
| blue | output | 2 | Blue level, 0 to 3 |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before any counting starts. This gives the divider a known phase when the enable-spacing and output-alignment properties begin watching. The stimulus holds reset low for several cycles at start-up. It also applies one pulse of random length, from 1 to 6 cycles, at a random point mid-run. Each pulse spans at least one whole clock edge, so the divider phase is always defined when checking resumes.

// File: rtl/vga_lr_pkg.sv
// Shared types and the image content function for the scaled-image display.
// Assumes image addresses fit in 12 bits or fewer for the pattern to be distinct.
package vga_lr_pkg;

    // One pixel: two bits per colour channel.
    typedef struct packed {
        logic [1:0] r;
        logic [1:0] g;
        logic [1:0] b;
    } rgb2_t;

    // Image content at a linear address: low six bits folded with the next six.
    function automatic rgb2_t pattern_word(input logic [31:0] addr);
        logic [5:0] lo;
        logic [5:0] hi;
        lo = addr[5:0];
        hi = addr[11:6];
        return rgb2_t'(lo ^ hi);
    endfunction

endpackage

// File: rtl/pix_enable_div.sv
// Divides the system clock into a one-cycle enable every DIV cycles.
// Assumes DIV >= 2; the enable is combinational from the phase counter.
module pix_enable_div #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic pix_en
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] phase;

    // Phase counter wrapping at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == CW'(DIV - 1))
            phase <= '0;
        else
            phase <= phase + CW'(1);
    end

    assign pix_en = (phase == CW'(DIV - 1));
endmodule

// File: rtl/scan_timing.sv
// Horizontal and vertical scan counters with sync and blank decoding.
// Assumes each porch is at least one count wide; sync outputs are active high.
module scan_timing #(
    parameter int H_VIS  = 200,
    parameter int H_FP   = 10,
    parameter int H_SYNC = 32,
    parameter int H_BP   = 22,
    parameter int V_VIS  = 600,
    parameter int V_FP   = 1,
    parameter int V_SYNC = 4,
    parameter int V_BP   = 23,
    parameter int HW     = 9,
    parameter int VW     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic          hsync_d,
    output logic          vsync_d,
    output logic          blank_d
);
    localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HS_ON   = H_VIS + H_FP;
    localparam int HS_OFF  = HS_ON + H_SYNC;
    localparam int VS_ON   = V_VIS + V_FP;
    localparam int VS_OFF  = VS_ON + V_SYNC;

    logic h_last;
    logic v_last;

    assign h_last = (h_cnt == HW'(H_TOTAL - 1));
    assign v_last = (v_cnt == VW'(V_TOTAL - 1));

    // Horizontal position: one step per pixel enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            h_cnt <= '0;
        else if (pix_en)
            h_cnt <= h_last ? '0 : h_cnt + HW'(1);
    end

    // Vertical position: one step at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            v_cnt <= '0;
        else if (pix_en && h_last)
            v_cnt <= v_last ? '0 : v_cnt + VW'(1);
    end

    // Sync and blank decode from the current position.
    always_comb begin
        blank_d = (h_cnt >= HW'(H_VIS)) || (v_cnt >= VW'(V_VIS));
        hsync_d = (h_cnt >= HW'(HS_ON)) && (h_cnt < HW'(HS_OFF));
        vsync_d = (v_cnt >= VW'(VS_ON)) && (v_cnt < VW'(VS_OFF));
    end
endmodule

// File: rtl/image_rom.sv
// Registered image lookup: maps a visible scan position to an image address
// and returns the stored word one enabled cycle later.
// Assumes H_SCALE and V_SCALE divide the visible window exactly.
module image_rom #(
    parameter int IMG_W   = 100,
    parameter int IMG_H   = 75,
    parameter int H_SCALE = 2,
    parameter int V_SCALE = 8,
    parameter int HW      = 9,
    parameter int VW      = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               visible,
    input  logic [HW-1:0]      h_pos,
    input  logic [VW-1:0]      v_pos,
    output vga_lr_pkg::rgb2_t  pix_q
);
    import vga_lr_pkg::*;

    localparam int DEPTH = IMG_W * IMG_H;

    logic [31:0] addr;

    // Image address, held at zero outside the visible window.
    always_comb begin
        if (visible)
            addr = (32'(v_pos) / V_SCALE) * IMG_W + 32'(h_pos) / H_SCALE;
        else
            addr = '0;
        if (addr >= DEPTH)
            addr = '0;
    end

    // Registered read, advancing with the pixel enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_q <= '0;
        else if (en)
            pix_q <= pattern_word(addr);
    end
endmodule

// File: rtl/vga_lowres_display.sv
// Top of the scaled-image display: divider, scan timing, image lookup and
// an output stage that keeps sync aligned with the registered colour.
// Assumes a free-running clock and a synchronous active-low reset.
module vga_lowres_display #(
    parameter int DIV     = 5,
    parameter int H_VIS   = 200,
    parameter int H_FP    = 10,
    parameter int H_SYNC  = 32,
    parameter int H_BP    = 22,
    parameter int V_VIS   = 600,
    parameter int V_FP    = 1,
    parameter int V_SYNC  = 4,
    parameter int V_BP    = 23,
    parameter int H_SCALE = 2,
    parameter int V_SCALE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       hsync,
    output logic       vsync,
    output logic [1:0] red,
    output logic [1:0] green,
    output logic [1:0] blue
);
    import vga_lr_pkg::*;

    localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);
    localparam int IMG_W   = H_VIS / H_SCALE;
    localparam int IMG_H   = V_VIS / V_SCALE;

    logic          pix_en;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          hsync_d;
    logic          vsync_d;
    logic          blank_d;
    logic          hs_q;
    logic          vs_q;
    logic          blank_q;
    rgb2_t         pix_q;

    pix_enable_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .pix_en (pix_en)
    );

    scan_timing #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_en  (pix_en),
        .h_cnt   (h_cnt),
        .v_cnt   (v_cnt),
        .hsync_d (hsync_d),
        .vsync_d (vsync_d),
        .blank_d (blank_d)
    );

    image_rom #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .H_SCALE(H_SCALE), .V_SCALE(V_SCALE),
        .HW(HW), .VW(VW)
    ) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pix_en),
        .visible (!blank_d),
        .h_pos   (h_cnt),
        .v_pos   (v_cnt),
        .pix_q   (pix_q)
    );

    // Timing stage matching the ROM read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q    <= 1'b0;
            vs_q    <= 1'b0;
            blank_q <= 1'b1;
        end else if (pix_en) begin
            hs_q    <= hsync_d;
            vs_q    <= vsync_d;
            blank_q <= blank_d;
        end
    end

    assign hsync = hs_q;
    assign vsync = vs_q;
    assign red   = blank_q ? 2'b00 : pix_q.r;
    assign green = blank_q ? 2'b00 : pix_q.g;
    assign blue  = blank_q ? 2'b00 : pix_q.b;
endmodule

// File: rtl/vga_lowres_checker.sv
// Property checker for the scaled-image display, bound into the top.
// Assumes reset is held low for at least one edge before checks begin.
module vga_lowres_checker #(
    parameter int DIV     = 5,
    parameter int H_TOTAL = 264,
    parameter int V_TOTAL = 628,
    parameter int HW      = 9,
    parameter int VW      = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_en,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt,
    input logic          hsync,
    input logic          vsync,
    input logic [1:0]    red,
    input logic [1:0]    green,
    input logic [1:0]    blue
);
    int gap;

    // Cycles since reset or since the last enable.
    always_ff @(posedge clk) begin
        if (!rst_n || pix_en)
            gap <= 0;
        else
            gap <= gap + 1;
    end

    AST_ENABLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |-> gap == DIV - 1); // R2
    AST_ENABLE_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |-> gap < DIV - 1); // R2
    AST_H_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(h_cnt) < H_TOTAL); // R3
    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && 32'(h_cnt) == H_TOTAL - 1) |=> h_cnt == '0); // R3
    AST_V_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(v_cnt) < V_TOTAL); // R4
    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_en && 32'(h_cnt) == H_TOTAL - 1) |=> $stable(v_cnt)); // R4
    AST_SYNC_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync || vsync) |-> {red, green, blue} == 6'd0); // R5
    AST_OUT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_en) |-> $stable({hsync, vsync, red, green, blue})); // R8
endmodule

bind vga_lowres_display vga_lowres_checker #(
    .DIV(DIV), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pix_en (pix_en),
    .h_cnt  (h_cnt),
    .v_cnt  (v_cnt),
    .hsync  (hsync),
    .vsync  (vsync),
    .red    (red),
    .green  (green),
    .blue   (blue)
);

// File: tb/vga_lowres_display_bench.sv
`timescale 1ns/1ps
module vga_lowres_display_bench;
    localparam int RUN_CYCLES = 160000;
    localparam int SHORT_VIS  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_a, vs_a, hs_b, vs_b;
    logic [1:0] r_a, g_a, b_a, r_b, g_b, b_b;

    int vectors = 0;
    int fails = 0;
    int n = 0;
    bit in_rst = 1'b1;
    bit done = 1'b0;
    longint tick = 0;
    longint hs_rise = -1, vs_rise = -1;
    bit hs_prev = 1'b0, vs_prev = 1'b0;

    always #5 clk = ~clk;

    vga_lowres_display u_vga_lowres_display (
        .clk(clk), .rst_n(rst_n), .hsync(hs_a), .vsync(vs_a),
        .red(r_a), .green(g_a), .blue(b_a)
    );

    vga_lowres_display #(.V_VIS(SHORT_VIS), .V_BP(3)) u_vga_lowres_display_short (
        .clk(clk), .rst_n(rst_n), .hsync(hs_b), .vsync(vs_b),
        .red(r_b), .green(g_b), .blue(b_b)
    );

    // Expected word from the image rule (R6, R7).
    function automatic logic [5:0] exp_word(input int h, input int v);
        int a;
        a = (v / 8) * 100 + h / 2;
        return 6'((a & 63) ^ ((a >> 6) & 63));
    endfunction

    function automatic void fail(input string req, input string what,
                                 input int act, input int exp);
        fails++;
        $display("FAIL %s %s actual=%0d expected=%0d at tick %0d", req, what, act, exp, tick);
    endfunction

    // Compare one instance against the position model.
    function automatic void check_inst(input logic hs, input logic vs,
                                       input logic [5:0] rgb, input int vvis,
                                       input int vtot);
        logic ehs, evs;
        logic [5:0] ergb;
        int p, h, v;
        string tag;
        ehs = 0; evs = 0; ergb = 0;
        if (in_rst || n < 5) begin
            tag = "R1";
        end else begin
            p = n / 5 - 1;
            h = p % 264;
            v = (p / 264) % vtot;
            ehs = (h >= 210) && (h < 242);
            evs = (v >= vvis + 1) && (v < vvis + 5);
            if (h < 200 && v < vvis) begin
                ergb = exp_word(h, v);
                tag = "R6 R7 R8";
            end else begin
                tag = "R5";
            end
        end
        vectors++;
        if (hs !== ehs) fail((in_rst || n < 5) ? "R1" : "R3", "hsync", int'(hs), int'(ehs));
        else if (vs !== evs) fail((in_rst || n < 5) ? "R1" : "R4", "vsync", int'(vs), int'(evs));
        else if (rgb !== ergb) fail(tag, "rgb", int'(rgb), int'(ergb));
    endfunction

    // Advance the model on each edge, then sample clear of the edge.
    always @(posedge clk) begin
        tick++;
        if (!rst_n) begin n = 0; in_rst = 1; end
        else begin n++; in_rst = 0; end
        #3;
        if (!done) begin
            check_inst(hs_a, vs_a, {r_a, g_a, b_a}, 600, 628);
            check_inst(hs_b, vs_b, {r_b, g_b, b_b}, SHORT_VIS, SHORT_VIS + 8);
            if (in_rst) begin hs_rise = -1; vs_rise = -1; end
            // Line period and hsync width (R2 R3).
            if (hs_a && !hs_prev) begin
                if (hs_rise >= 0) begin
                    vectors++;
                    if (tick - hs_rise != 1320) fail("R2 R3", "line period", int'(tick - hs_rise), 1320);
                end
                hs_rise = tick;
            end
            if (!hs_a && hs_prev && hs_rise >= 0) begin
                vectors++;
                if (tick - hs_rise != 160) fail("R3", "hsync width", int'(tick - hs_rise), 160);
            end
            // Frame period and vsync width on the short frame (R4).
            if (vs_b && !vs_prev) begin
                if (vs_rise >= 0) begin
                    vectors++;
                    if (tick - vs_rise != 32 * 1320) fail("R4", "frame period", int'(tick - vs_rise), 32 * 1320);
                end
                vs_rise = tick;
            end
            if (!vs_b && vs_prev && vs_rise >= 0) begin
                vectors++;
                if (tick - vs_rise != 4 * 1320) fail("R4", "vsync width", int'(tick - vs_rise), 4 * 1320);
            end
            hs_prev = hs_a;
            vs_prev = vs_b;
        end
    end

    initial begin
        int at, len;
        void'($urandom(32'd2024));
        at = 60000 + int'($urandom % 20000);
        len = 1 + int'($urandom % 6);
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                repeat (at) @(negedge clk);
                rst_n = 1'b0;           // mid-run reset pulse (R1)
                repeat (len) @(negedge clk);
                rst_n = 1'b1;
                repeat (RUN_CYCLES - at - len) @(negedge clk);
            end
            begin
                repeat (190000) @(negedge clk);
                fails++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, RUN_CYCLES);
            end
        join_any
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule